// File: doc/BRIEF.md
# DRAM Bank Command Timing Monitor

This block watches the decoded command stream that a memory controller sends to a single multi-bank DRAM device. It reports every command that arrives sooner than the device's spacing rules allow. Each cycle may carry at most one command. A command is described by a valid strobe, a 3-bit type code and a bank index. The monitor keeps a saturating down-counter for each spacing rule, either per bank or for the whole device. A counter is loaded when its triggering command is seen. A later command that finds its counter still non-zero is flagged.

All spacings are counted in interface clock cycles and are parameters, so one instance can be set for any speed grade. The defaults track 32 banks and use the fastest grade. The monitor also keeps an open or closed state for every bank, so it can report accesses that do not fit that state. Violations appear on a vector with one bit per rule. A sticky error flag gathers them until reset.

Top module: `bank_timing_monitor`

## Requirements
- R1: A synchronous active-high reset clears every violation bit and the error flag, stops every counter and closes every bank. After reset a read is flagged only as a state violation, and an activate is not flagged at all.
- R2: An activate (type code 0) to a bank fewer than T_RC (default 28) cycles after the previous activate to that same bank sets violation bit 0.
- R3: A precharge (type code 1) to a bank fewer than T_RAS (default 20) cycles after that bank's activate sets bit 1. At exactly T_RAS cycles it is accepted.
- R4: An activate to a bank fewer than T_RP (default 8) cycles after that bank's precharge sets bit 2. At exactly T_RP cycles it is accepted.
- R5: Device-wide spacing applies across banks. Two precharges to any banks fewer than T_PP (default 8) cycles apart set bit 3. Two activates to any banks fewer than T_RR (default 8) cycles apart set bit 4.
- R6: A read (code 2) or write (code 3) fewer than T_RCD (default 9) cycles after its bank's activate sets bit 5. At exactly T_RCD cycles it is accepted.
- R7: Column commands are read, write and retire. Two of them to any banks fewer than T_CC (default 4) cycles apart set bit 6.
- R8: A retire (code 4) fewer than T_RTR (default 8) cycles after the most recent write to any bank sets bit 7.
- R9: A precharge to a bank fewer than T_RDP (default 4) cycles after a read to that bank sets bit 8. A precharge fewer than T_RTP (default 4) cycles after a retire to that bank sets bit 9.
- R10: Bit 10 marks a state violation. It is set by an activate to a bank that is already open, or by a read or write to a closed bank. An activate opens its bank and a precharge closes it.
- R11: The violation bits for a command appear in the cycle after that command is sampled, and last for that one cycle only.
- R12: The error flag rises together with the first violation bit and stays high until reset.
- R13: A command that violates a rule still takes effect: it loads its counters and updates its bank state. Cycles with the valid strobe low, and type codes 5 to 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_type_i | input | 3 | Command code: 0 activate, 1 precharge, 2 read, 3 write, 4 retire |
| cmd_bank_i | input | 5 | Target bank index |
| viol_o | output | 11 | Per-rule violation pulses, bit numbers as in R2 to R10 |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions assume that each cycle carries at most one command. They also assume that the bank index stays below the bank count, and that reset is applied before the first command. Every directed scenario starts from a fresh reset. Each one then issues commands at computed cycle gaps, so that exactly one chosen rule is broken, or a rule is met exactly at its boundary. Targets above bank 10 are never used, and the type codes beyond retire are issued only in the scenario that checks they are ignored.

// File: rtl/btm_pkg.sv
`timescale 1ns/1ps
package btm_pkg;
    localparam logic [2:0] CMD_ACT = 3'd0;
    localparam logic [2:0] CMD_PRE = 3'd1;
    localparam logic [2:0] CMD_RD  = 3'd2;
    localparam logic [2:0] CMD_WR  = 3'd3;
    localparam logic [2:0] CMD_RET = 3'd4;

    localparam int V_RC    = 0;
    localparam int V_RAS   = 1;
    localparam int V_RP    = 2;
    localparam int V_PP    = 3;
    localparam int V_RR    = 4;
    localparam int V_RCD   = 5;
    localparam int V_CC    = 6;
    localparam int V_RTR   = 7;
    localparam int V_RDP   = 8;
    localparam int V_RTP   = 9;
    localparam int V_STATE = 10;
    localparam int NUM_RULES = 11;

    typedef struct packed {
        logic [NUM_RULES-1:0] viol;
        logic                 err;
    } mon_state_t;

    function automatic int gap_width(input int t);
        return (t > 1) ? $clog2(t) : 1;
    endfunction
endpackage

// File: rtl/gap_counter.sv
`timescale 1ns/1ps
module gap_counter #(
    parameter int T = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o
);
    localparam int W = btm_pkg::gap_width(T);
    localparam logic [W-1:0] LOAD = W'(T - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    AST_LOAD_MAKES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (load_i && T > 1) |=> busy_o) else $error("counter idle after load"); // R11
endmodule

// File: rtl/bank_slice.sv
`timescale 1ns/1ps
module bank_slice #(
    parameter int T_RC  = 28,
    parameter int T_RAS = 20,
    parameter int T_RP  = 8,
    parameter int T_RCD = 9,
    parameter int T_RDP = 4,
    parameter int T_RTP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic act_i,
    input  logic pre_i,
    input  logic rd_i,
    input  logic ret_i,
    output logic open_o,
    output logic rc_busy_o,
    output logic ras_busy_o,
    output logic rp_busy_o,
    output logic rcd_busy_o,
    output logic rdp_busy_o,
    output logic rtp_busy_o
);
    logic act_hit, pre_hit, rd_hit, ret_hit;
    logic open_d, open_q;

    assign act_hit = sel_i & act_i;
    assign pre_hit = sel_i & pre_i;
    assign rd_hit  = sel_i & rd_i;
    assign ret_hit = sel_i & ret_i;

    gap_counter #(.T(T_RC))  u_rc  (.clk(clk), .rst(rst), .load_i(act_hit), .busy_o(rc_busy_o));
    gap_counter #(.T(T_RAS)) u_ras (.clk(clk), .rst(rst), .load_i(act_hit), .busy_o(ras_busy_o));
    gap_counter #(.T(T_RCD)) u_rcd (.clk(clk), .rst(rst), .load_i(act_hit), .busy_o(rcd_busy_o));
    gap_counter #(.T(T_RP))  u_rp  (.clk(clk), .rst(rst), .load_i(pre_hit), .busy_o(rp_busy_o));
    gap_counter #(.T(T_RDP)) u_rdp (.clk(clk), .rst(rst), .load_i(rd_hit),  .busy_o(rdp_busy_o));
    gap_counter #(.T(T_RTP)) u_rtp (.clk(clk), .rst(rst), .load_i(ret_hit), .busy_o(rtp_busy_o));

    always_comb begin
        open_d = open_q;
        if (act_hit)
            open_d = 1'b1;
        else if (pre_hit)
            open_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= open_d;
    end

    assign open_o = open_q;

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        act_hit |=> open_o) else $error("bank not open after activate"); // R10
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        pre_hit |=> !open_o) else $error("bank open after precharge"); // R10
    AST_RAS_INSIDE_RC: assert property (@(posedge clk) disable iff (rst)
        (T_RC >= T_RAS && ras_busy_o) |-> rc_busy_o) else $error("ras window outlives rc window"); // R3
endmodule

// File: rtl/device_timers.sv
`timescale 1ns/1ps
module device_timers #(
    parameter int T_PP  = 8,
    parameter int T_RR  = 8,
    parameter int T_CC  = 4,
    parameter int T_RTR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic pre_i,
    input  logic col_i,
    input  logic wr_i,
    output logic pp_busy_o,
    output logic rr_busy_o,
    output logic cc_busy_o,
    output logic rtr_busy_o
);
    gap_counter #(.T(T_PP))  u_pp  (.clk(clk), .rst(rst), .load_i(pre_i), .busy_o(pp_busy_o));
    gap_counter #(.T(T_RR))  u_rr  (.clk(clk), .rst(rst), .load_i(act_i), .busy_o(rr_busy_o));
    gap_counter #(.T(T_CC))  u_cc  (.clk(clk), .rst(rst), .load_i(col_i), .busy_o(cc_busy_o));
    gap_counter #(.T(T_RTR)) u_rtr (.clk(clk), .rst(rst), .load_i(wr_i),  .busy_o(rtr_busy_o));

    AST_CC_AFTER_COL: assert property (@(posedge clk) disable iff (rst)
        (col_i && T_CC > 1) |=> cc_busy_o) else $error("column spacing not armed"); // R7
endmodule

// File: rtl/bank_timing_monitor.sv
`timescale 1ns/1ps
module bank_timing_monitor #(
    parameter int NUM_BANKS = 32,
    parameter int T_RC  = 28,
    parameter int T_RAS = 20,
    parameter int T_RP  = 8,
    parameter int T_PP  = 8,
    parameter int T_RR  = 8,
    parameter int T_RCD = 9,
    parameter int T_CC  = 4,
    parameter int T_RTR = 8,
    parameter int T_RDP = 4,
    parameter int T_RTP = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid_i,
    input  logic [2:0]                    cmd_type_i,
    input  logic [BANK_W-1:0]             cmd_bank_i,
    output logic [btm_pkg::NUM_RULES-1:0] viol_o,
    output logic                          err_o
);
    import btm_pkg::*;

    logic act_w, pre_w, rd_w, wr_w, ret_w, col_w;
    logic [NUM_BANKS-1:0] open_v, rc_v, ras_v, rp_v, rcd_v, rdp_v, rtp_v;
    logic pp_busy, rr_busy, cc_busy, rtr_busy;
    logic open_sel;
    mon_state_t st_d, st_q;

    assign act_w = cmd_valid_i && (cmd_type_i == CMD_ACT);
    assign pre_w = cmd_valid_i && (cmd_type_i == CMD_PRE);
    assign rd_w  = cmd_valid_i && (cmd_type_i == CMD_RD);
    assign wr_w  = cmd_valid_i && (cmd_type_i == CMD_WR);
    assign ret_w = cmd_valid_i && (cmd_type_i == CMD_RET);
    assign col_w = rd_w | wr_w | ret_w;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_slice #(
            .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP),
            .T_RCD(T_RCD), .T_RDP(T_RDP), .T_RTP(T_RTP)
        ) u_slice (
            .clk(clk), .rst(rst),
            .sel_i(cmd_bank_i == BANK_W'(b)),
            .act_i(act_w), .pre_i(pre_w), .rd_i(rd_w), .ret_i(ret_w),
            .open_o(open_v[b]),
            .rc_busy_o(rc_v[b]), .ras_busy_o(ras_v[b]), .rp_busy_o(rp_v[b]),
            .rcd_busy_o(rcd_v[b]), .rdp_busy_o(rdp_v[b]), .rtp_busy_o(rtp_v[b])
        );
    end

    device_timers #(
        .T_PP(T_PP), .T_RR(T_RR), .T_CC(T_CC), .T_RTR(T_RTR)
    ) u_dev (
        .clk(clk), .rst(rst),
        .act_i(act_w), .pre_i(pre_w), .col_i(col_w), .wr_i(wr_w),
        .pp_busy_o(pp_busy), .rr_busy_o(rr_busy),
        .cc_busy_o(cc_busy), .rtr_busy_o(rtr_busy)
    );

    assign open_sel = open_v[cmd_bank_i];

    always_comb begin
        st_d      = st_q;
        st_d.viol = '0;
        if (act_w) begin
            st_d.viol[V_RC]    = rc_v[cmd_bank_i];
            st_d.viol[V_RP]    = rp_v[cmd_bank_i];
            st_d.viol[V_RR]    = rr_busy;
            st_d.viol[V_STATE] = open_sel;
        end
        if (pre_w) begin
            st_d.viol[V_RAS] = ras_v[cmd_bank_i];
            st_d.viol[V_PP]  = pp_busy;
            st_d.viol[V_RDP] = rdp_v[cmd_bank_i];
            st_d.viol[V_RTP] = rtp_v[cmd_bank_i];
        end
        if (rd_w || wr_w) begin
            st_d.viol[V_RCD]   = rcd_v[cmd_bank_i];
            st_d.viol[V_CC]    = cc_busy;
            st_d.viol[V_STATE] = !open_sel;
        end
        if (ret_w) begin
            st_d.viol[V_CC]  = cc_busy;
            st_d.viol[V_RTR] = rtr_busy;
        end
        st_d.err = st_q.err | (|st_d.viol);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign viol_o = st_q.viol;
    assign err_o  = st_q.err;

    AST_VIOL_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (|viol_o) |-> $past(cmd_valid_i)) else $error("violation without command"); // R13
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o) else $error("error flag dropped"); // R12
    AST_ERR_WITH_VIOL: assert property (@(posedge clk) disable iff (rst)
        (|viol_o) |-> err_o) else $error("violation not gathered"); // R12
    AST_CLOSED_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ((rd_w || wr_w) && !open_sel) |=> viol_o[V_STATE]) else $error("closed access missed"); // R10
endmodule

// File: tb/test_bank_timing_monitor.sv
`timescale 1ns/1ps
module test_bank_timing_monitor;
    import btm_pkg::*;

    localparam int NR = NUM_RULES;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [2:0]    ctype = 3'd0;
    logic [4:0]    cbank = 5'd0;
    logic [NR-1:0] viol;
    logic          err;
    logic [NR-1:0] v;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_timing_monitor i_bank_timing_monitor (
        .clk(clk), .rst(rst), .cmd_valid_i(valid), .cmd_type_i(ctype),
        .cmd_bank_i(cbank), .viol_o(viol), .err_o(err)
    );

    function automatic logic [NR-1:0] bit_of(input int idx);
        return NR'(1) << idx;
    endfunction

    task automatic chk(input string tag, input logic [NR-1:0] got, input logic [NR-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // issue a command 'gap' cycles after the previous one, return the violation vector it caused
    task automatic send(input logic [2:0] t, input int b, input int gap, output logic [NR-1:0] res);
        repeat (gap - 1) @(posedge clk);
        @(negedge clk);
        valid = 1'b1; ctype = t; cbank = 5'(b);
        @(posedge clk);
        #1 res = viol;
        valid = 1'b0;
    endtask

    task automatic ghost(input logic [2:0] t, input int b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0; ctype = t; cbank = 5'(b);
            @(posedge clk);
        end
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 viol after reset", viol, '0);
        chk1("R1 err after reset", err, 1'b0);
        send(CMD_RD, 3, 1, v);
        chk("R1 read after reset", v, bit_of(V_STATE));
        do_reset();
        send(CMD_ACT, 0, 1, v);
        chk("R1 activate after reset", v, '0);
    endtask

    task automatic t_row_cycle();
        do_reset();
        send(CMD_ACT, 5, 1, v);
        send(CMD_PRE, 5, 19, v);
        chk("R3 precharge at 19", v, bit_of(V_RAS));
        send(CMD_ACT, 5, 8, v);
        chk("R2 activate at 27", v, bit_of(V_RC));
        do_reset();
        send(CMD_ACT, 5, 1, v);
        send(CMD_PRE, 5, 20, v);
        chk("R3 precharge at 20", v, '0);
        send(CMD_ACT, 5, 8, v);
        chk("R2 R4 activate at 28", v, '0);
    endtask

    task automatic t_precharge_gap();
        do_reset();
        send(CMD_ACT, 2, 1, v);
        send(CMD_PRE, 2, 25, v);
        chk("R4 precharge clean", v, '0);
        send(CMD_ACT, 2, 5, v);
        chk("R4 activate 5 after precharge", v, bit_of(V_RP));
    endtask

    task automatic t_device_wide();
        do_reset();
        send(CMD_ACT, 0, 1, v);
        send(CMD_ACT, 1, 4, v);
        chk("R5 activate other bank at 4", v, bit_of(V_RR));
        send(CMD_ACT, 2, 6, v);
        chk("R13 violating activate reloads", v, bit_of(V_RR));
        send(CMD_PRE, 0, 15, v);
        chk("R5 first precharge", v, '0);
        send(CMD_PRE, 1, 7, v);
        chk("R5 precharge other bank at 7", v, bit_of(V_PP));
        send(CMD_PRE, 2, 8, v);
        chk("R5 precharge at 8", v, '0);
    endtask

    task automatic t_ras_to_cas();
        do_reset();
        send(CMD_ACT, 7, 1, v);
        send(CMD_RD, 7, 8, v);
        chk("R6 read at 8", v, bit_of(V_RCD));
        send(CMD_WR, 7, 4, v);
        chk("R6 write at 12", v, '0);
        do_reset();
        send(CMD_ACT, 7, 1, v);
        send(CMD_WR, 7, 9, v);
        chk("R6 write at 9", v, '0);
    endtask

    task automatic t_column_gap();
        do_reset();
        send(CMD_ACT, 1, 1, v);
        send(CMD_ACT, 2, 8, v);
        send(CMD_RD, 1, 9, v);
        chk("R7 first read", v, '0);
        send(CMD_WR, 2, 3, v);
        chk("R7 write 3 after read", v, bit_of(V_CC));
        send(CMD_RD, 1, 4, v);
        chk("R7 read 4 after write", v, '0);
    endtask

    task automatic t_retire();
        do_reset();
        send(CMD_ACT, 3, 1, v);
        send(CMD_WR, 3, 10, v);
        send(CMD_RET, 3, 7, v);
        chk("R8 retire at 7", v, bit_of(V_RTR));
        send(CMD_RET, 3, 8, v);
        chk("R8 later retire", v, '0);
        do_reset();
        send(CMD_ACT, 3, 1, v);
        send(CMD_WR, 3, 10, v);
        send(CMD_RET, 3, 8, v);
        chk("R8 retire at 8", v, '0);
    endtask

    task automatic t_col_to_pre();
        do_reset();
        send(CMD_ACT, 4, 1, v);
        send(CMD_RD, 4, 20, v);
        send(CMD_PRE, 4, 3, v);
        chk("R9 precharge 3 after read", v, bit_of(V_RDP));
        do_reset();
        send(CMD_ACT, 6, 1, v);
        send(CMD_WR, 6, 10, v);
        send(CMD_RET, 6, 10, v);
        send(CMD_PRE, 6, 3, v);
        chk("R9 precharge 3 after retire", v, bit_of(V_RTP));
        do_reset();
        send(CMD_ACT, 6, 1, v);
        send(CMD_RD, 6, 20, v);
        send(CMD_PRE, 6, 4, v);
        chk("R9 precharge 4 after read", v, '0);
    endtask

    task automatic t_state();
        do_reset();
        send(CMD_ACT, 9, 1, v);
        send(CMD_ACT, 9, 30, v);
        chk("R10 activate open bank", v, bit_of(V_STATE));
        send(CMD_WR, 10, 5, v);
        chk("R10 write closed bank", v, bit_of(V_STATE));
    endtask

    task automatic t_pulse_sticky();
        do_reset();
        send(CMD_RD, 0, 1, v);
        chk("R11 pulse present", v, bit_of(V_STATE));
        chk1("R12 error rises", err, 1'b1);
        @(posedge clk); #1;
        chk("R11 pulse gone", viol, '0);
        repeat (6) @(posedge clk);
        #1 chk1("R12 error held", err, 1'b1);
        do_reset();
        chk1("R12 error cleared", err, 1'b0);
    endtask

    task automatic t_ignore();
        do_reset();
        ghost(CMD_ACT, 0, 3);
        send(CMD_RD, 0, 1, v);
        chk("R13 strobe low activate ignored", v, bit_of(V_STATE));
        send(3'd5, 0, 5, v);
        chk("R13 code 5 no flag", v, '0);
        send(CMD_RD, 0, 5, v);
        chk("R13 code 5 no state change", v, bit_of(V_STATE));
        send(CMD_ACT, 1, 5, v);
        ghost(CMD_PRE, 1, 2);
        send(CMD_RD, 1, 10, v);
        chk("R13 strobe low precharge ignored", v, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_row_cycle();
        t_precharge_gap();
        t_device_wide();
        t_ras_to_cas();
        t_column_gap();
        t_retire();
        t_col_to_pre();
        t_state();
        t_pulse_sticky();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule